// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters from a host into asynchronous serial frames on one output line. The host writes a character into a holding register. On a baud strobe the character moves into a separate frame shifter, so the next character can be written while the current one is still leaving the line. Each frame is a low start bit, then the data bits with the least significant first, then a high stop bit. The line rests high between frames.

A mode input picks 8-bit or 9-bit characters. In 9-bit mode the extra bit comes from a host control input, which the host can use as a parity bit it computes itself. Two flags report progress. The holding-empty flag shows when another character may be written. The line-done flag shows that the shifter has nothing left to send. Each flag has its own interrupt enable, and the two requests share one interrupt output. The baud rate is supplied from outside as a single-cycle strobe.

Top module: `uart_tx_buf`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `txd` is 1, `dre` is 1, `tc` is 1 and `irq` is 0.
- R2: In 8-bit mode (`mode9`=0) a frame is one 0 start bit, then `wr_data` bits 0 to 7 in that order, then one 1 stop bit. Each bit lasts from one `baud_tick` to the next, and the start bit appears in the cycle after the tick that loads the shifter.
- R3: In 9-bit mode (`mode9`=1, sampled on the loading tick) the value that `ninth_bit` had at the write is sent after data bit 7 and before the stop bit.
- R4: A write (`wr_en`=1) clears `dre` in the next cycle. If the shifter is idle, the next `baud_tick` moves the character into the shifter and sets `dre` again in that same cycle.
- R5: `tc` falls in the cycle in which a start bit first appears on `txd`. It rises, with `txd` high, after the tick that ends a stop bit when no character is waiting.
- R6: If a character is waiting when a stop bit ends, the same tick starts the next start bit with no idle bit in between, and `tc` stays 0.
- R7: With `tx_en`=0 the line is held at 1 and no character is taken, so `dre` stays 0. If `tx_en` drops during a frame, the frame is abandoned: `txd` and `tc` are 1 in the next cycle.
- R8: `irq` is registered: one cycle after `(empty_ie & dre) | (done_ie & tc)` changes, `irq` takes its value.
- R9: A second write before the waiting character is taken replaces it, so only the last one written is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| mode9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| ninth_bit | input | 1 | Extra bit stored with each write, used in 9-bit mode |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to send |
| baud_tick | input | 1 | One-cycle strobe that marks each bit period |
| empty_ie | input | 1 | Interrupt enable for the holding-empty flag |
| done_ie | input | 1 | Interrupt enable for the line-done flag |
| txd | output | 1 | Serial output line |
| dre | output | 1 | Holding register empty |
| tc | output | 1 | Transmission complete |
| irq | output | 1 | Interrupt request |

## Verification
A wrong bit counter or a wrong shift register contents shows up on `txd` within one baud period: a bit is missing, repeated or placed in the wrong slot. A wrong flag state shows up as `dre` or `tc` at the wrong level in the cycle right after the loading tick or the ending tick. Because `irq` is derived from those flags one cycle later, a wrong flag also makes the interrupt wrong by the following cycle. Back-to-back frames and abandoned frames are where the counter and the flags interact most, so both are checked bit by bit.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_BUSY = 1'b1
  } sh_state_e;
endpackage

// File: rtl/uart_tx_holding.sv
module uart_tx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ext,
  input  logic              take,
  output logic [DATA_W:0]   hold_word,
  output logic              empty
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_word <= '0;
      empty     <= 1'b1;
    end else if (wr_en) begin
      // a write always wins: the newest character is the one kept
      hold_word <= {wr_ext, wr_data};
      empty     <= 1'b0;
    end else if (take) begin
      empty <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter bit EXT_EN   = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tx_en,
  input  logic            baud_tick,
  input  logic            mode9,
  input  logic            have_data,
  input  logic [DATA_W:0] load_word,
  output logic            take,
  output logic            txd,
  output logic            done
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(DATA_W + 3);

  sh_state_e          state;
  logic [FRAME_W-1:0] sr;
  logic [CNT_W-1:0]   left;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   frame_len;
  logic               last_bit;

  generate
    if (EXT_EN) begin : g_ext
      always_comb begin
        if (mode9) begin
          frame     = {1'b1, load_word[DATA_W], load_word[DATA_W-1:0], 1'b0};
          frame_len = LEN_LONG;
        end else begin
          frame     = {2'b11, load_word[DATA_W-1:0], 1'b0};
          frame_len = LEN_SHORT;
        end
      end
    end else begin : g_noext
      always_comb begin
        frame     = {2'b11, load_word[DATA_W-1:0], 1'b0};
        frame_len = LEN_SHORT;
      end
    end
  endgenerate

  assign last_bit = (state == SH_BUSY) && (left == CNT_W'(1));
  assign take     = tx_en && baud_tick && have_data &&
                    ((state == SH_IDLE) || last_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SH_IDLE;
      sr    <= '1;
      left  <= '0;
      txd   <= 1'b1;
      done  <= 1'b1;
    end else if (!tx_en) begin
      state <= SH_IDLE;
      sr    <= '1;
      left  <= '0;
      txd   <= 1'b1;
      done  <= 1'b1;
    end else if (baud_tick) begin
      if (take) begin
        state <= SH_BUSY;
        txd   <= frame[0];
        sr    <= {1'b1, frame[FRAME_W-1:1]};
        left  <= frame_len;
        done  <= 1'b0;
      end else if (last_bit) begin
        state <= SH_IDLE;
        txd   <= 1'b1;
        left  <= '0;
        done  <= 1'b1;
      end else if (state == SH_BUSY) begin
        txd  <= sr[0];
        sr   <= {1'b1, sr[FRAME_W-1:1]};
        left <= left - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq (
  input  logic clk,
  input  logic rst,
  input  logic empty_ie,
  input  logic done_ie,
  input  logic empty,
  input  logic done,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (empty_ie && empty) || (done_ie && done);
  end
endmodule

// File: rtl/uart_tx_buf.sv
module uart_tx_buf #(
  parameter int DATA_W = 8,
  parameter bit EXT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              mode9,
  input  logic              ninth_bit,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              baud_tick,
  input  logic              empty_ie,
  input  logic              done_ie,
  output logic              txd,
  output logic              dre,
  output logic              tc,
  output logic              irq
);
  logic [DATA_W:0] hold_word;
  logic            take;

  uart_tx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .wr_ext(ninth_bit), .take(take), .hold_word(hold_word), .empty(dre)
  );

  uart_tx_shifter #(.DATA_W(DATA_W), .EXT_EN(EXT_EN)) u_shift (
    .clk(clk), .rst(rst), .tx_en(tx_en), .baud_tick(baud_tick),
    .mode9(mode9), .have_data(!dre), .load_word(hold_word),
    .take(take), .txd(txd), .done(tc)
  );

  uart_tx_irq u_irq (
    .clk(clk), .rst(rst), .empty_ie(empty_ie), .done_ie(done_ie),
    .empty(dre), .done(tc), .irq(irq)
  );
endmodule

// File: rtl/uart_tx_buf_chk.sv
module uart_tx_buf_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_en,
  input logic              wr_en,
  input logic              empty_ie,
  input logic              done_ie,
  input logic              txd,
  input logic              dre,
  input logic              tc,
  input logic              irq
);
  // R7: disabled transmitter leaves the line high
  assert_line_idle_off_R7: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> txd);

  // R4: a write leaves the holding register occupied next cycle
  assert_write_fills_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !dre);

  // R4: the holding register only empties when a start bit goes out
  assert_take_starts_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(dre) |-> !txd);

  // R5: complete drops only together with a start bit
  assert_tc_fall_start_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(tc) |-> !txd);

  // R5: while complete, the line rests high
  assert_tc_idle_line_R5: assert property (@(posedge clk) disable iff (rst)
    tc |-> txd);

  // R8: interrupt follows the enabled flags one cycle later
  assert_irq_follow_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == $past((empty_ie && dre) || (done_ie && tc))));
endmodule

bind uart_tx_buf uart_tx_buf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .tx_en(tx_en), .wr_en(wr_en),
  .empty_ie(empty_ie), .done_ie(done_ie),
  .txd(txd), .dre(dre), .tc(tc), .irq(irq)
);

// File: tb/uart_tx_buf_bench.sv
module uart_tx_buf_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0, mode9 = 1'b0, ninth_bit = 1'b0;
  logic       wr_en = 1'b0, baud_tick = 1'b0;
  logic [7:0] wr_data = '0;
  logic       empty_ie = 1'b0, done_ie = 1'b0;
  logic       txd, dre, tc, irq;
  int         n_run = 0, n_fail = 0;
  bit         finished = 0;

  always #4 clk = ~clk;

  uart_tx_buf u_uart_tx_buf (
    .clk(clk), .rst(rst), .tx_en(tx_en), .mode9(mode9), .ninth_bit(ninth_bit),
    .wr_en(wr_en), .wr_data(wr_data), .baud_tick(baud_tick),
    .empty_ie(empty_ie), .done_ie(done_ie),
    .txd(txd), .dre(dre), .tc(tc), .irq(irq)
  );

  // {mode9, ninth_bit, data}
  localparam logic [9:0] VEC [6] = '{
    {1'b0, 1'b0, 8'hA5}, {1'b0, 1'b1, 8'h00}, {1'b0, 1'b0, 8'hFF},
    {1'b1, 1'b1, 8'h32}, {1'b1, 1'b0, 8'h81}, {1'b1, 1'b1, 8'h5C}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d, input logic b9);
    @(negedge clk); wr_en = 1'b1; wr_data = d; ninth_bit = b9;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); baud_tick = 1'b1;
    @(negedge clk); baud_tick = 1'b0;
  endtask

  function automatic logic exp_bit(input logic [9:0] v, input int i);
    int len = v[9] ? 11 : 10;
    if (i == 0) return 1'b0;
    if (i <= 8) return v[i-1];
    if (i == len - 1) return 1'b1;
    return v[8];
  endfunction

  // sends one full character and checks every bit; leaves line idle
  task automatic send_frame(input logic [9:0] v, input string req);
    int len = v[9] ? 11 : 10;
    mode9 = v[9];
    do_write(v[7:0], v[8]);
    check(dre == 1'b0, "R4 write clears empty", dre, 0);
    do_tick();
    check(txd == 1'b0 && dre == 1'b1, "R4 load on tick", {txd, dre}, 1);
    check(tc == 1'b0, "R5 tc falls at start", tc, 0);
    for (int i = 1; i < len; i++) begin
      do_tick();
      check(txd == exp_bit(v, i), req, txd, exp_bit(v, i));
    end
    do_tick();
    check(tc == 1'b1 && txd == 1'b1, "R5 tc after stop", {tc, txd}, 3);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(txd && dre && tc && !irq, "R1 reset state", {txd, dre, tc, irq}, 14);
    rst = 1'b0;
    @(negedge clk);
    check(txd && dre && tc && !irq, "R1 after release", {txd, dre, tc, irq}, 14);
    tx_en = 1'b1;

    // R2 / R3 table walk
    foreach (VEC[k]) send_frame(VEC[k], VEC[k][9] ? "R3 nine-bit frame" : "R2 eight-bit frame");

    // R6 back to back
    mode9 = 1'b0;
    do_write(8'h3C, 1'b0);
    do_tick();
    do_write(8'hC3, 1'b0);
    check(dre == 1'b0, "R6 second waits", dre, 0);
    for (int i = 1; i < 10; i++) do_tick();
    do_tick();
    check(txd == 1'b0 && tc == 1'b0 && dre == 1'b1, "R6 no gap", {txd, tc, dre}, 1);
    for (int i = 1; i < 10; i++) begin
      do_tick();
      check(txd == exp_bit({2'b00, 8'hC3}, i), "R6 second frame", txd, exp_bit({2'b00, 8'hC3}, i));
    end
    do_tick();
    check(tc == 1'b1, "R6 done after second", tc, 1);

    // R9 last write wins
    do_write(8'h11, 1'b0);
    do_write(8'hE8, 1'b0);
    do_tick();
    for (int i = 1; i < 10; i++) begin
      do_tick();
      check(txd == exp_bit({2'b00, 8'hE8}, i), "R9 newest sent", txd, exp_bit({2'b00, 8'hE8}, i));
    end
    do_tick();

    // R7 disabled
    tx_en = 1'b0;
    do_write(8'h0F, 1'b0);
    do_tick(); do_tick();
    check(dre == 1'b0 && txd == 1'b1, "R7 nothing taken", {dre, txd}, 1);
    tx_en = 1'b1;
    do_tick();
    check(txd == 1'b0 && tc == 1'b0, "R7 starts when enabled", {txd, tc}, 0);
    do_tick(); do_tick();
    @(negedge clk); tx_en = 1'b0;
    @(negedge clk);
    check(txd == 1'b1 && tc == 1'b1, "R7 abandon frame", {txd, tc}, 3);
    tx_en = 1'b1;

    // R8 interrupt
    @(negedge clk); empty_ie = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R8 empty irq", irq, 1);
    do_write(8'h55, 1'b0);
    @(negedge clk);
    check(irq == 1'b0, "R8 irq drops with full", irq, 0);
    empty_ie = 1'b0; done_ie = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R8 done irq", irq, 1);
    do_tick();
    @(negedge clk);
    check(irq == 1'b0, "R8 irq drops while busy", irq, 0);
    done_ie = 1'b0;
    for (int i = 1; i < 11; i++) do_tick();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule